// File: doc/BRIEF.md
# Flag Offset Register Load Sequencer

This block keeps the two threshold offsets that a FIFO's almost-empty and almost-full flags compare against. Each offset is wider than a byte. It is stored as an 8-bit low register and a high register that holds the remaining bits above bit 7. With the default depth of 8192, the high register is 5 bits wide and each offset is 13 bits. The two assembled offsets are exported continuously to the flag comparison logic, which lives outside this block.

A single active-low pin, `ld_n`, has two jobs. Its level while reset is applied is captured as a strap. If it is low during reset, the block enters offset-load mode. If it is high during reset, the pin acts only as a second write enable for the FIFO.

In offset-load mode, each write-clock edge that sees `ld_n` and `wen_n` both low stores the input bus into one of the four registers. The write sequencer's four states name the registers in the order they are filled:

- `EMPTY_LO`
- `EMPTY_HI`
- `FULL_LO`
- `FULL_HI`

The sequencer moves to the next state on every load write. From `FULL_HI` it returns to `EMPTY_LO`. Without a load write it holds its state, so a load that was stopped partway resumes at the next register.

A separate read sequencer in the read-clock domain has the same four states and the same ring. It advances on each readback edge, where `ld_n` and both read enables are low. On that edge it copies the selected register, zero-extended, into the output register. Both sequencers return to `EMPTY_LO` on reset.

Top module: `flag_offset_loader`

## Requirements
- R1: Reset restores both offsets to 7, clears `dout` to zero, and returns both sequencers to `EMPTY_LO`.
- R2: `load_mode` is 1 after a reset during which `ld_n` was low, and 0 after a reset during which `ld_n` was high. After reset it keeps its value.
- R3: In load mode, successive write edges with `ld_n`=0 and `wen_n`=0 fill the registers in a fixed order:
  - empty-offset bits 7:0 from `din[7:0]`,
  - then empty-offset bits 12:8 from `din[4:0]`,
  - then full-offset bits 7:0 from `din[7:0]`,
  - then full-offset bits 12:8 from `din[4:0]`.
- R4: The fifth consecutive load write stores into the empty-offset low byte again.
- R5: Raising `ld_n` between load writes keeps the write position. The next load write goes to the register after the last one written.
- R6: In load mode, successive read edges with `ld_n`=0 and both read enables at 0 place the registers on `dout` in the R3 order, registered on that edge. Bits of `dout` above the register's width are 0.
- R7: The read position wraps after four readbacks and moves independently of the write position.
- R8: With `ld_n`=0 and `wen_n`=1, the offsets do not change. With `ld_n`=0 and only one read enable low, `dout` and the read position do not change.
- R9: `fifo_we` is 1 exactly when `ld_n`=1 and `wen_n`=0. Such a write leaves the offsets unchanged.
- R10: `fifo_re` is 1 when both read enables are 0, except in load mode while `ld_n`=0.
- R11: When not in load mode, `ld_n`=0 with `wen_n`=0 changes no offset, and `ld_n`=0 with both read enables low leaves `dout` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled on both clocks |
| ld_n | input | 1 | Load select (active low); strapped at reset to choose the mode |
| wen_n | input | 1 | Write enable, active low |
| ren_a_n | input | 1 | First read enable, active low |
| ren_b_n | input | 1 | Second read enable, active low |
| din | input | 9 | Input data bus |
| dout | output | 9 | Offset readback register |
| fifo_we | output | 1 | Write strobe to the FIFO array |
| fifo_re | output | 1 | Read strobe to the FIFO array |
| load_mode | output | 1 | Strapped load mode indicator |
| empty_ofs | output | 13 | Assembled almost-empty offset |
| full_ofs | output | 13 | Assembled almost-full offset |

## Verification
The hardest situation to reach from the ports is a write sequencer that has been left in the middle of its ring while the read sequencer sits at a different position. The only evidence of either position is which register the next access touches.

The stimulus reaches this state in four steps:

1. Load all four registers.
2. Perform a wrapping fifth load write.
3. Raise `ld_n` for idle cycles, then issue one more load write and check that it landed in the empty high part.
4. Perform a fifth readback, apply partial read enables, then read once more and check that the output is the empty high part.

The mode strap is exercised by resetting with each level of `ld_n` and checking that load writes are refused when the strap is high.

// File: rtl/ofs_pkg.sv
package ofs_pkg;

    // Ring order of the four offset registers; bit 1 selects the offset,
    // bit 0 selects the part (low byte or high bits).
    typedef enum logic [1:0] {
        EMPTY_LO = 2'd0,
        EMPTY_HI = 2'd1,
        FULL_LO  = 2'd2,
        FULL_HI  = 2'd3
    } ofs_slot_e;

endpackage

// File: rtl/ofs_write_seq.sv
module ofs_write_seq
    import ofs_pkg::*;
#(
    parameter int OFS_W       = 13,
    parameter int DATA_W      = 9,
    parameter int DEFAULT_OFS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              wen_n,
    input  logic [DATA_W-1:0] din,
    output logic              load_mode,
    output logic [OFS_W-1:0]  empty_ofs,
    output logic [OFS_W-1:0]  full_ofs
);
    localparam int HI_W = OFS_W - 8;
    localparam logic [OFS_W-1:0] DEF = OFS_W'(DEFAULT_OFS);

    ofs_slot_e   state_q, state_d;
    logic        load_op;
    logic [1:0]  we_lo, we_hi;
    logic [7:0]      lo_q [2];
    logic [HI_W-1:0] hi_q [2];

    assign load_op = load_mode & ~ld_n & ~wen_n;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= EMPTY_LO;
            load_mode <= ~ld_n;
        end else begin
            state_q   <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (load_op) begin
            unique case (state_q)
                EMPTY_LO: state_d = EMPTY_HI;
                EMPTY_HI: state_d = FULL_LO;
                FULL_LO:  state_d = FULL_HI;
                FULL_HI:  state_d = EMPTY_LO;
            endcase
        end
    end

    // Output decode: register write strobes
    always_comb begin
        we_lo = 2'b00;
        we_hi = 2'b00;
        if (load_op) begin
            unique case (state_q)
                EMPTY_LO: we_lo[0] = 1'b1;
                EMPTY_HI: we_hi[0] = 1'b1;
                FULL_LO:  we_lo[1] = 1'b1;
                FULL_HI:  we_hi[1] = 1'b1;
            endcase
        end
    end

    for (genvar g = 0; g < 2; g++) begin : g_ofs
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q[g] <= DEF[7:0];
                hi_q[g] <= DEF[OFS_W-1:8];
            end else begin
                if (we_lo[g]) lo_q[g] <= din[7:0];
                if (we_hi[g]) hi_q[g] <= din[HI_W-1:0];
            end
        end
    end

    assign empty_ofs = {hi_q[0], lo_q[0]};
    assign full_ofs  = {hi_q[1], lo_q[1]};

    // R8: without a load write, neither position nor offsets move
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load_op |=> ($stable(state_q) && $stable(empty_ofs) && $stable(full_ofs)));

    // R4: a load write in the last slot wraps the ring
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (load_op && state_q == FULL_HI) |=> (state_q == EMPTY_LO));

    // R3: a load write changes at most one offset
    a_r3_one_offset: assert property (@(posedge clk) disable iff (!rst_n)
        load_op |=> ($stable(empty_ofs) || $stable(full_ofs)));

endmodule

// File: rtl/ofs_read_seq.sv
module ofs_read_seq
    import ofs_pkg::*;
#(
    parameter int OFS_W  = 13,
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              ren_a_n,
    input  logic              ren_b_n,
    input  logic [OFS_W-1:0]  empty_ofs,
    input  logic [OFS_W-1:0]  full_ofs,
    output logic [DATA_W-1:0] dout,
    output logic              fifo_re
);
    localparam int HI_W = OFS_W - 8;

    ofs_slot_e   state_q, state_d;
    logic        mode_q;
    logic        both_ren;
    logic        rd_op;
    logic [7:0]  sel_val;

    assign both_ren = ~ren_a_n & ~ren_b_n;
    assign rd_op    = mode_q & ~ld_n & both_ren;
    assign fifo_re  = both_ren & ~(mode_q & ~ld_n);

    // State register (read domain keeps its own copy of the strap)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= EMPTY_LO;
            mode_q  <= ~ld_n;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (rd_op) begin
            unique case (state_q)
                EMPTY_LO: state_d = EMPTY_HI;
                EMPTY_HI: state_d = FULL_LO;
                FULL_LO:  state_d = FULL_HI;
                FULL_HI:  state_d = EMPTY_LO;
            endcase
        end
    end

    // Output select for the current slot
    always_comb begin
        sel_val = '0;
        unique case (state_q)
            EMPTY_LO: sel_val = empty_ofs[7:0];
            EMPTY_HI: sel_val = 8'(empty_ofs[OFS_W-1:8]);
            FULL_LO:  sel_val = full_ofs[7:0];
            FULL_HI:  sel_val = 8'(full_ofs[OFS_W-1:8]);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     dout <= '0;
        else if (rd_op) dout <= DATA_W'(sel_val);
    end

    // R7: no readback, no movement of position or output
    a_r7_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_op |=> ($stable(state_q) && $stable(dout)));

    // R6: bits above the byte are always zero on readback
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_op |=> (dout[DATA_W-1:8] == '0));

    // R6: a high-part readback never sets bits above the high width
    a_r6_hi_width: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_op && state_q[0]) |=> (dout[7:HI_W] == '0));

endmodule

// File: rtl/flag_offset_loader.sv
module flag_offset_loader #(
    parameter int DEPTH       = 8192,
    parameter int DATA_W      = 9,
    parameter int DEFAULT_OFS = 7
) (
    input  logic                      wclk,
    input  logic                      rclk,
    input  logic                      rst_n,
    input  logic                      ld_n,
    input  logic                      wen_n,
    input  logic                      ren_a_n,
    input  logic                      ren_b_n,
    input  logic [DATA_W-1:0]         din,
    output logic [DATA_W-1:0]         dout,
    output logic                      fifo_we,
    output logic                      fifo_re,
    output logic                      load_mode,
    output logic [$clog2(DEPTH)-1:0]  empty_ofs,
    output logic [$clog2(DEPTH)-1:0]  full_ofs
);
    localparam int OFS_W = $clog2(DEPTH);

    // Normal FIFO write: same rule in both strap modes
    assign fifo_we = ld_n & ~wen_n;

    ofs_write_seq #(
        .OFS_W(OFS_W), .DATA_W(DATA_W), .DEFAULT_OFS(DEFAULT_OFS)
    ) u_wr (
        .clk(wclk), .rst_n(rst_n), .ld_n(ld_n), .wen_n(wen_n), .din(din),
        .load_mode(load_mode), .empty_ofs(empty_ofs), .full_ofs(full_ofs)
    );

    ofs_read_seq #(
        .OFS_W(OFS_W), .DATA_W(DATA_W)
    ) u_rd (
        .clk(rclk), .rst_n(rst_n), .ld_n(ld_n), .ren_a_n(ren_a_n),
        .ren_b_n(ren_b_n), .empty_ofs(empty_ofs), .full_ofs(full_ofs),
        .dout(dout), .fifo_re(fifo_re)
    );

    // R9: a FIFO write never alters the offsets
    a_r9_fifo_write_clean: assert property (@(posedge wclk) disable iff (!rst_n)
        fifo_we |=> ($stable(empty_ofs) && $stable(full_ofs)));

    // R2: the strap is held after reset
    a_r2_strap_held: assert property (@(posedge wclk) disable iff (!rst_n)
        1'b1 |=> $stable(load_mode));

endmodule

// File: tb/flag_offset_loader_test.sv
module flag_offset_loader_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n, ld_n, wen_n, ren_a_n, ren_b_n;
    logic [8:0]  din;
    logic [8:0]  dout;
    logic        fifo_we, fifo_re, load_mode;
    logic [12:0] empty_ofs, full_ofs;

    int n_chk = 0;
    int n_bad = 0;

    flag_offset_loader uut (
        .wclk(clk), .rclk(clk), .rst_n(rst_n), .ld_n(ld_n), .wen_n(wen_n),
        .ren_a_n(ren_a_n), .ren_b_n(ren_b_n), .din(din), .dout(dout),
        .fifo_we(fifo_we), .fifo_re(fifo_re), .load_mode(load_mode),
        .empty_ofs(empty_ofs), .full_ofs(full_ofs)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        ld_n = 1'b1; wen_n = 1'b1; ren_a_n = 1'b1; ren_b_n = 1'b1; din = '0;
    endtask

    // Drive at negedge, let one posedge pass, sample 1 ns later
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic do_reset(input logic strap_ld_n);
        @(negedge clk);
        idle(); ld_n = strap_ld_n; rst_n = 1'b0;
        step(); step();
        @(negedge clk); rst_n = 1'b1; idle();
        step();
    endtask

    task automatic load_wr(input logic [8:0] v);
        @(negedge clk); idle(); ld_n = 1'b0; wen_n = 1'b0; din = v;
        step();
        @(negedge clk); idle();
    endtask

    task automatic read_bk();
        @(negedge clk); idle(); ld_n = 1'b0; ren_a_n = 1'b0; ren_b_n = 1'b0;
        step();
        @(negedge clk); idle();
    endtask

    task automatic t_reset_load_mode();
        do_reset(1'b0);
        check("R1 empty default", empty_ofs, 13'h007);
        check("R1 full default", full_ofs, 13'h007);
        check("R1 dout cleared", dout, 0);
        check("R2 strap low -> load mode", load_mode, 1);
    endtask

    task automatic t_full_load();
        load_wr(9'h1A5); check("R3 empty lo", empty_ofs, 13'h00A5);
        load_wr(9'h013); check("R3 empty hi", empty_ofs, 13'h13A5);
        load_wr(9'h0C3); check("R3 full lo", full_ofs, 13'h00C3);
        load_wr(9'h1FF); check("R3 full hi", full_ofs, 13'h1FC3);
        check("R3 empty untouched by full writes", empty_ofs, 13'h13A5);
    endtask

    task automatic t_readback();
        read_bk(); check("R6 read empty lo", dout, 9'h0A5);
        read_bk(); check("R6 read empty hi", dout, 9'h013);
        read_bk(); check("R6 read full lo", dout, 9'h0C3);
        read_bk(); check("R6 read full hi", dout, 9'h01F);
        read_bk(); check("R7 read wraps to empty lo", dout, 9'h0A5);
    endtask

    task automatic t_wrap_and_partial();
        load_wr(9'h055); check("R4 fifth write to empty lo", empty_ofs, 13'h1355);
        repeat (3) begin @(negedge clk); idle(); step(); end
        load_wr(9'h002); check("R5 resume at empty hi", empty_ofs, 13'h0255);
        check("R5 full unchanged", full_ofs, 13'h1FC3);
    endtask

    task automatic t_noop();
        @(negedge clk); idle(); ld_n = 1'b0; wen_n = 1'b1; din = 9'h1EE;
        step(); step();
        check("R8 no load without wen empty", empty_ofs, 13'h0255);
        check("R8 no load without wen full", full_ofs, 13'h1FC3);
        @(negedge clk); idle(); ld_n = 1'b0; ren_a_n = 1'b0;
        step(); step();
        check("R8 one ren holds dout", dout, 9'h0A5);
        @(negedge clk); idle(); ld_n = 1'b0; ren_b_n = 1'b0;
        step();
        check("R8 other ren holds dout", dout, 9'h0A5);
        read_bk(); check("R7 read position kept at empty hi", dout, 9'h002);
    endtask

    task automatic t_fifo_strobes();
        @(negedge clk); idle(); wen_n = 1'b0; din = 9'h1FF; #1;
        check("R9 fifo_we on ld high wen low", fifo_we, 1);
        step();
        check("R9 fifo write leaves empty", empty_ofs, 13'h0255);
        check("R9 fifo write leaves full", full_ofs, 13'h1FC3);
        @(negedge clk); idle(); ld_n = 1'b0; wen_n = 1'b0; #1;
        check("R9 no fifo_we when ld low", fifo_we, 0);
        @(negedge clk); idle(); ren_a_n = 1'b0; ren_b_n = 1'b0; #1;
        check("R10 fifo_re with ld high", fifo_re, 1);
        @(negedge clk); idle(); ren_a_n = 1'b0; #1;
        check("R10 no fifo_re on one ren", fifo_re, 0);
        @(negedge clk); idle(); ld_n = 1'b0; ren_a_n = 1'b0; ren_b_n = 1'b0; #1;
        check("R10 no fifo_re in offset readback", fifo_re, 0);
        @(negedge clk); idle();
    endtask

    task automatic t_reset_pointers();
        do_reset(1'b0);
        check("R1 offsets restored", empty_ofs, 13'h007);
        load_wr(9'h0FF);
        check("R1 write pointer back at empty lo", empty_ofs, 13'h00FF);
        read_bk();
        check("R1 read pointer back at empty lo", dout, 9'h0FF);
    endtask

    task automatic t_two_enable();
        do_reset(1'b1);
        check("R2 strap high -> no load mode", load_mode, 0);
        load_wr(9'h0AA);
        check("R11 load refused empty", empty_ofs, 13'h007);
        check("R11 load refused full", full_ofs, 13'h007);
        @(negedge clk); idle(); ld_n = 1'b0; ren_a_n = 1'b0; ren_b_n = 1'b0; #1;
        check("R10 fifo_re when not in load mode", fifo_re, 1);
        step();
        check("R11 no readback when not in load mode", dout, 0);
        @(negedge clk); idle(); ld_n = 1'b0; wen_n = 1'b0; #1;
        check("R11 ld low blocks fifo write", fifo_we, 0);
        @(negedge clk); idle();
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
    end

    initial begin
        idle(); rst_n = 1'b0;
        t_reset_load_mode();
        t_full_load();
        t_readback();
        t_wrap_and_partial();
        t_noop();
        t_fifo_strobes();
        t_reset_pointers();
        t_two_enable();
        summary();
    end
endmodule